// File: doc/BRIEF.md
# Damped Sliding DFT Fundamental Extractor

This block tracks the fundamental of a periodic signal. Each time an external oscillator strobes the sample-enable input, the block takes one signed fixed-point sample and advances a recursive single-bin DFT by one step. The DFT is tuned to bin 1 of a 128-sample window. Because the strobe rate is kept at 128 times the input frequency, the window always covers exactly one input period. Two results come out: the in-phase part of the fundamental, with no phase shift, and its quadrature counterpart. A phase-locked loop downstream correlates the quadrature result with the raw input to steer the oscillator.

The recursion has two stages. First, a damped comb subtracts the sample taken 128 strobes earlier, weighted by r^128. Second, a complex resonator rotates its state by r·e^{j2π/128} on every strobe. With r = 0.9997, the pole sits just inside the unit circle, so rounding errors die out instead of building up. The pole cancels the comb zero at bin 1, which means the whole filter acts as a damped 128-tap FIR. Its output is scaled by 2/128, so a bin-1 tone comes out at close to its input amplitude.

Top module: `sdft_fund_extract`

## Requirements
- R1: A synchronous active-low reset sets both outputs to zero, clears the valid flag and empties the sample history. For the first 128 strobes after reset, the delayed sample in the comb reads as zero.
- R2: The valid flag is high in exactly the cycle after each cycle in which the strobe is high, and low in every other cycle.
- R3: In a cycle without the strobe, the sample input is ignored. The outputs, the history and the resonator state keep their values.
- R4: On each strobe, the comb value is c = x − floor(x_old·K/2^18). Here x_old is the sample taken 128 strobes earlier, and K = 252267, which is r^128 in 18 fraction bits. Samples are 20-bit two's complement with 18 fraction bits, and c is 21 bits wide.
- R5: On each strobe, the 27-bit two's-complement resonator state (re, im) is updated to re' = c + floor((a·re − b·im)/2^18) and im' = floor((b·re + a·im)/2^18), with a = 261750 (r·cos(2π/128)) and b = 12859 (r·sin(2π/128)).
- R6: The in-phase and quadrature outputs are floor(re/64) and floor(im/64). Both are 20-bit two's complement with 18 fraction bits, and they change at the same clock edge at which the valid flag rises.
- R7: The history is a ring of 128 entries. The sample taken at strobe k is the one subtracted at strobe k+128, and the sample taken at strobe k+128 is the one subtracted at strobe k+256.
- R8: A cosine with amplitude A and a period of 128 strobes produces an output magnitude sqrt(re²+im²) within 0.02·A of 0.981·A, from 128 strobes after it starts.
- R9: From 128 strobes after a constant input D starts, the output magnitude stays below 0.02·|D|. The same bound, relative to A, holds for a cosine of amplitude A whose period is 128/3 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en_i | input | 1 | Sample strobe from the external oscillator |
| smp_i | input | 20 | Signed sample, 18 fraction bits |
| re_o | output | 20 | In-phase fundamental, 18 fraction bits |
| im_o | output | 20 | Quadrature fundamental, 18 fraction bits |
| valid_o | output | 1 | High for one cycle after each strobe |

## Verification
The assertions assume that the strobe is a plain level sampled at each clock edge, and that samples stay within ±1.0. Under that bound the 27-bit resonator state cannot wrap, so pointer and state-hold properties are enough, with no overflow guard. The stimulus keeps every sample at or below 0.9 in magnitude: tones and constants at 0.5, random samples up to ±0.9. During idle gaps the sample input carries random values, which tests that samples are ignored between strobes. Strobes arrive both back to back and spaced out, so the hold and valid properties are exercised in both cases.

// File: rtl/sdft_pkg.sv
// Shared defaults for the damped sliding DFT. The coefficients are the
// Q2.18 roundings of r^N, r*cos(2*pi/N) and r*sin(2*pi/N) for r = 0.9997
// and N = 128. A change of N or r needs new values here.
package sdft_pkg;
    localparam int unsigned SDFT_DATA_W  = 20;
    localparam int unsigned SDFT_FRAC_W  = 18;
    localparam int unsigned SDFT_WIN_LEN = 128;
    localparam int          SDFT_K_N     = 252267;
    localparam int          SDFT_COS_K   = 261750;
    localparam int          SDFT_SIN_K   = 12859;
endpackage

// File: rtl/sdft_comb.sv
// Damped comb stage: c = x - r^N * x[n-N].
// The history is a ring of WIN_LEN registers, and the write pointer moves on
// each strobe. The slot under the pointer holds the oldest sample, so it is
// read and then overwritten in the same strobe cycle.
// Assumes 0 < K_N < 2^FRAC_W, so the weighted product never exceeds |x_old|.
module sdft_comb #(
    parameter int unsigned DATA_W  = 20,
    parameter int unsigned FRAC_W  = 18,
    parameter int unsigned WIN_LEN = 128,
    parameter int          K_N     = 252267
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic signed [DATA_W:0]   comb_o
);
    localparam int unsigned PTR_W  = $clog2(WIN_LEN);
    localparam int unsigned COEF_W = FRAC_W + 2;
    localparam int unsigned CW     = DATA_W + 1;
    localparam int unsigned PW     = DATA_W + COEF_W;
    localparam logic [PTR_W-1:0]         LAST_IDX = PTR_W'(WIN_LEN - 1);
    localparam logic signed [COEF_W-1:0] KN_C     = COEF_W'(K_N);

    logic signed [DATA_W-1:0] hist_q [WIN_LEN];
    logic [PTR_W-1:0]         ptr_q;
    logic signed [DATA_W-1:0] oldest;
    logic signed [PW-1:0]     weighted;

    // Store the new sample over the oldest one and advance the ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WIN_LEN); i++) hist_q[i] <= '0;
            ptr_q <= '0;
        end else if (en_i) begin
            hist_q[ptr_q] <= x_i;
            ptr_q         <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        end
    end

    // Weight the oldest sample by r^N and subtract it from the new one.
    always_comb begin
        oldest   = hist_q[ptr_q];
        weighted = (PW'(oldest) * PW'(KN_C)) >>> FRAC_W;
        comb_o   = CW'(x_i) - CW'(weighted);
    end

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ptr_q == LAST_IDX) |=> (ptr_q == '0));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(ptr_q));
endmodule

// File: rtl/sdft_resonator.sv
// Complex resonator with its pole at r*e^{j*2*pi/N}:
// S <= c + (a + j*b) * S, using 18-bit fraction coefficients.
// Every product is truncated toward minus infinity. The state width must
// cover the window gain times the largest comb value, so nothing wraps.
module sdft_resonator #(
    parameter int unsigned IN_W   = 21,
    parameter int unsigned ACC_W  = 27,
    parameter int unsigned FRAC_W = 18,
    parameter int          COS_K  = 261750,
    parameter int          SIN_K  = 12859
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic signed [IN_W-1:0]  c_i,
    output logic signed [ACC_W-1:0] re_o,
    output logic signed [ACC_W-1:0] im_o
);
    localparam int unsigned COEF_W = FRAC_W + 2;
    localparam int unsigned PW     = ACC_W + COEF_W;
    localparam logic signed [COEF_W-1:0] A_C = COEF_W'(COS_K);
    localparam logic signed [COEF_W-1:0] B_C = COEF_W'(SIN_K);

    logic signed [ACC_W-1:0] re_q, im_q, nxt_re, nxt_im;
    logic signed [PW-1:0]    ar, bi, br, ai, rot_re, rot_im;

    // Rotate and damp the present state, then inject the comb value.
    always_comb begin
        ar     = PW'(re_q) * PW'(A_C);
        bi     = PW'(im_q) * PW'(B_C);
        br     = PW'(re_q) * PW'(B_C);
        ai     = PW'(im_q) * PW'(A_C);
        rot_re = (ar - bi) >>> FRAC_W;
        rot_im = (br + ai) >>> FRAC_W;
        nxt_re = ACC_W'(rot_re) + ACC_W'(c_i);
        nxt_im = ACC_W'(rot_im);
    end

    // Take the new state only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_q <= '0;
            im_q <= '0;
        end else if (en_i) begin
            re_q <= nxt_re;
            im_q <= nxt_im;
        end
    end

    assign re_o = re_q;
    assign im_o = im_q;

    // R3
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(re_q) && $stable(im_q)));
endmodule

// File: rtl/sdft_fund_extract.sv
// Top of the damped sliding DFT fundamental extractor (bin 1).
// It chains the comb and the resonator and scales the resonator state by
// 2/WIN_LEN, so a bin-1 tone comes out near its input amplitude. The
// sample strobe must arrive WIN_LEN times per input period, and samples
// must stay within +/-1.0 so that the state does not wrap.
// WIN_LEN must be a power of two.
module sdft_fund_extract
    import sdft_pkg::*;
#(
    parameter int unsigned DATA_W  = SDFT_DATA_W,
    parameter int unsigned FRAC_W  = SDFT_FRAC_W,
    parameter int unsigned WIN_LEN = SDFT_WIN_LEN,
    parameter int          K_N     = SDFT_K_N,
    parameter int          COS_K   = SDFT_COS_K,
    parameter int          SIN_K   = SDFT_SIN_K
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_en_i,
    input  logic signed [DATA_W-1:0] smp_i,
    output logic signed [DATA_W-1:0] re_o,
    output logic signed [DATA_W-1:0] im_o,
    output logic                     valid_o
);
    localparam int unsigned LOG2_WIN  = $clog2(WIN_LEN);
    localparam int unsigned ACC_W     = DATA_W + LOG2_WIN;
    localparam int unsigned OUT_SHIFT = LOG2_WIN - 1;

    logic signed [DATA_W:0]  comb_val;
    logic signed [ACC_W-1:0] re_acc, im_acc;
    logic                    valid_q;

    sdft_comb #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .WIN_LEN(WIN_LEN),
        .K_N    (K_N)
    ) comb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (smp_en_i),
        .x_i   (smp_i),
        .comb_o(comb_val)
    );

    sdft_resonator #(
        .IN_W  (DATA_W + 1),
        .ACC_W (ACC_W),
        .FRAC_W(FRAC_W),
        .COS_K (COS_K),
        .SIN_K (SIN_K)
    ) reso_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en_i (smp_en_i),
        .c_i  (comb_val),
        .re_o (re_acc),
        .im_o (im_acc)
    );

    // Flag the cycle in which the outputs first show a new result.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= smp_en_i;
    end

    // Scale by 2/WIN_LEN to get the amplitude of the fundamental.
    assign re_o    = DATA_W'(re_acc >>> OUT_SHIFT);
    assign im_o    = DATA_W'(im_acc >>> OUT_SHIFT);
    assign valid_o = valid_q;

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en_i |=> valid_o);

    // R2
    valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en_i |=> !valid_o);

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en_i |=> ($stable(re_o) && $stable(im_o)));
endmodule

// File: tb/sdft_fund_extract_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver runs an independent bit-exact model of R4-R6
// and queues the expected outputs. The monitor samples 1 ns after each
// rising edge and compares against the queue.
module sdft_fund_extract_tb_top;
    localparam int DW = 20;
    localparam int NW = 128;
    localparam longint KN = 252267;
    localparam longint CA = 261750;
    localparam longint SB = 12859;
    localparam real ONE = 262144.0;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en_i = 1'b0;
    logic signed [DW-1:0] smp_i = '0;
    logic signed [DW-1:0] re_o, im_o;
    logic valid_o;

    int n_chk = 0;
    int n_bad = 0;

    longint hist [NW];
    int     hp;
    longint st_re, st_im;
    longint exp_q [$];

    always #2.5 clk = ~clk;

    sdft_fund_extract dut_i (
        .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en_i), .smp_i(smp_i),
        .re_o(re_o), .im_o(im_o), .valid_o(valid_o)
    );

    function automatic longint wrap(longint v, int w);
        return (v <<< (64 - w)) >>> (64 - w);
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NW; i++) hist[i] = 0;
        hp = 0; st_re = 0; st_im = 0;
    endtask

    // Step the model and push the expected {re, im} pair.
    task automatic model_step(longint x);
        longint c, nre, nim;
        c = wrap(x - ((hist[hp] * KN) >>> 18), DW + 1);
        hist[hp] = x;
        hp = (hp + 1) % NW;
        nre = wrap(c + ((CA * st_re - SB * st_im) >>> 18), DW + 7);
        nim = wrap((SB * st_re + CA * st_im) >>> 18, DW + 7);
        st_re = nre; st_im = nim;
        exp_q.push_back(wrap(nre >>> 6, DW));
        exp_q.push_back(wrap(nim >>> 6, DW));
    endtask

    // Driver: one strobe, then 'gap' idle cycles with random samples on the input.
    task automatic drive(longint x, int gap);
        @(negedge clk);
        smp_i = DW'(x);
        smp_en_i = 1'b1;
        model_step(x);
        if (gap > 0) begin
            @(negedge clk);
            smp_en_i = 1'b0;
            smp_i = DW'($urandom);
            for (int g = 1; g < gap; g++) begin
                @(negedge clk);
                smp_i = DW'($urandom);
            end
        end
    endtask

    task automatic idle(int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            smp_en_i = 1'b0;
            smp_i = DW'($urandom);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(posedge clk); #1;
        // R1 reset state at the ports
        check(re_o == 0, "R1 re after reset", re_o, 0);
        check(im_o == 0, "R1 im after reset", im_o, 0);
        check(valid_o == 0, "R1 valid after reset", valid_o, 0);
    endtask

    task automatic check_mag(real lo, real hi, string req);
        real mr, mi, mag;
        idle(2);
        @(posedge clk); #1;
        mr = real'(re_o) / ONE;
        mi = real'(im_o) / ONE;
        mag = $sqrt(mr * mr + mi * mi);
        check(mag >= lo && mag <= hi, req,
              longint'(mag * ONE), longint'((lo + hi) * ONE / 2.0));
    endtask

    // Monitor: compare on valid; outside valid, check that the outputs hold.
    initial begin
        longint last_re, last_im, er, ei;
        last_re = 0; last_im = 0;
        forever begin
            @(posedge clk); #1;
            if (!rst_n) begin
                exp_q.delete();
                last_re = re_o; last_im = im_o;
            end else if (exp_q.size() > 0) begin
                er = exp_q.pop_front();
                ei = exp_q.pop_front();
                check(valid_o == 1'b1, "R2 valid after strobe", valid_o, 1);
                check(re_o == er, "R4 R5 R6 in-phase", re_o, er);
                check(im_o == ei, "R4 R5 R6 quadrature", im_o, ei);
                last_re = re_o; last_im = im_o;
            end else begin
                check(valid_o == 1'b0, "R2 valid low when idle", valid_o, 0);
                check(re_o == last_re && im_o == last_im,
                      "R3 outputs hold without strobe", re_o, last_re);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R7 impulse: history subtraction at strobes 128 and 256, with idle gaps (R3)
        drive(65536, 3);
        for (int k = 1; k < 300; k++) drive(0, (k % 7 == 0) ? 2 : 0);
        idle(3);

        // R8 bin-1 cosine of amplitude 0.5, strobe every second cycle
        for (int k = 0; k < 4 * NW; k++)
            drive(longint'($rtoi(0.5 * ONE * $cos(2.0 * PI * k / NW))), 1);
        check_mag(0.4806, 0.5006, "R8 tone magnitude");

        // R1 history cleared by a reset in mid-run
        do_reset();
        for (int k = 0; k < 200; k++) drive(-98304 + 977 * k, 0);
        idle(2);

        // R9 constant input 0.5 is rejected
        do_reset();
        for (int k = 0; k < 3 * NW; k++) drive(131072, 0);
        check_mag(0.0, 0.01, "R9 DC leakage");

        // R9 third harmonic is rejected
        for (int k = 0; k < 3 * NW; k++)
            drive(longint'($rtoi(0.5 * ONE * $cos(6.0 * PI * k / NW))), 0);
        check_mag(0.0, 0.01, "R9 third harmonic leakage");

        // R4 random signed samples within +/-0.9 with mixed spacing
        for (int k = 0; k < 300; k++)
            drive(longint'($urandom_range(471860)) - 235930, k % 3);
        idle(4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule